// File: doc/BRIEF.md
# Serial Configuration Slave for a Clock-Generator Register File

This block is the two-wire configuration port of a clock generator. A fast system clock oversamples the serial clock and data lines. The block finds start and stop conditions and shifts bytes in and out. It keeps a small bank of 8-bit control registers that drive the clock-gating and frequency-select logic directly, as one parallel vector. The bank starts from fixed power-on values.

Transfers always use block access and always begin at register 0. A write frame carries the device address, then a command byte and a length byte, then register data. The slave acknowledges the command and length bytes but does not use them. A read frame returns a length byte first, then the register contents. Neither frame has a register offset. The master may end a write after any whole byte. The output stage is modelled as a single pull-low enable, so the pad itself and the wired-AND bus are left to the surrounding logic.

Top module: `cfgs_slave`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2 (7-bit address 0x69 with the write bit 0) and the address byte 0xD3 (read bit 1). For any other address byte it gives no acknowledge, ignores the rest of the frame and leaves every register unchanged.
- R2: In a write, the two bytes after the address are acknowledged and discarded. The data bytes that follow are acknowledged and stored into register 0, 1, 2, and so on in arrival order. Register k appears on `cfg_regs[8k+7:8k]`.
- R3: A stop after any acknowledged data byte ends the write. Registers that already received a byte keep the new value, and registers not reached keep their previous value.
- R4: Data bytes written after the last register are acknowledged and change no register.
- R5: After a 0xD3 address, the slave sends the register count (6) and then registers 0 to 5, each MSB first. A read past the last register returns 0xFF. The master acknowledges with SDA low. A not-acknowledge (SDA high) ends the transfer with SDA released.
- R6: Bit 0 of register 0 is stored and driven on `cfg_regs[0]`, but it always reads back as 0.
- R7: After reset, the registers hold 0x07, 0xFF, 0xFF, 0x00, 0x00, 0x00 (registers 0 to 5), and `sda_out_en` is 0.
- R8: The slave pulls SDA low from the SCL fall that ends the 8th bit of a byte until the next SCL fall. `sda_out_en` changes only after an SCL fall, a start or a stop.
- R9: A start or stop in the middle of a byte abandons that byte and changes no register. A start begins a new address phase at once, including a repeated start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad (wired-AND level) |
| sda_out_en | output | 1 | 1 pulls the data line low |
| cfg_regs | output | NUM_REGS*8 | Register bank, register k in bits 8k+7:8k |

## Verification
The bench builds the slave with its default parameters: two synchronizer stages, six registers and device address 0x69. Six registers let one write frame run two bytes past the end of the bank, and let one read frame run one byte past it. This exercises both overflow paths next to the normal ones. The short synchronizer allows a bus bit of 32 system clocks. At that rate, aborted bytes, repeated starts, rejected addresses and the exact acknowledge window all fit within one run.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // returned for any read beyond the register bank
    localparam byte_t RD_PAST_END = 8'hFF;

    // frame position of the first data byte in a write (address, command, length)
    localparam byte_t WR_DATA_POS = 8'd3;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_RECV,
        LK_ACK_OUT,
        LK_SEND,
        LK_ACK_IN
    } link_st_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic  en;
        byte_t idx;
        byte_t data;
    } wr_req_t;

    function automatic byte_t reset_value(input int unsigned idx);
        case (idx)
            0:       return 8'h07;
            1, 2:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic byte_t readback_mask(input int unsigned idx);
        return (idx == 0) ? 8'hFE : 8'hFF;
    endfunction

    function automatic byte_t sat_inc(input byte_t v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

endpackage

// File: rtl/cfgs_bus_sampler.sv
module cfgs_bus_sampler
    import cfgs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q;
    logic scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_comb begin
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile
    import cfgs_pkg::*;
#(
    parameter int NUM_REGS = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               wr,
    input  byte_t                 rd_idx,
    output byte_t                 rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    localparam byte_t NREG_B = byte_t'(NUM_REGS);

    byte_t regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= reset_value(g);
            else if (wr.en && wr.idx == byte_t'(g))
                regs_q[g] <= wr.data;
        end
        assign regs_flat[g*8 +: 8] = regs_q[g];
    end

    always_comb begin
        rd_data = RD_PAST_END;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == byte_t'(i))
                rd_data = regs_q[i] & readback_mask(i);
        end
    end

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> wr.idx < NREG_B); // R4

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(regs_flat)); // R3

endmodule

// File: rtl/cfgs_link.sv
module cfgs_link
    import cfgs_pkg::*;
#(
    parameter int         NUM_REGS = 6,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  byte_t   rd_data,
    output byte_t   rd_idx,
    output wr_req_t wr,
    output logic    sda_drive
);

    localparam byte_t NREG_B = byte_t'(NUM_REGS);

    link_st_e   st;
    logic [3:0] bit_cnt;
    byte_t      shreg;
    byte_t      fidx;
    logic       is_read;
    logic       ack_seen;
    byte_t      nxt_fidx;
    byte_t      tx_byte;

    assign nxt_fidx = sat_inc(fidx);
    assign rd_idx   = nxt_fidx - 8'd2;
    assign tx_byte  = (nxt_fidx == 8'd1) ? NREG_B : rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= LK_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            fidx      <= '0;
            is_read   <= 1'b0;
            ack_seen  <= 1'b0;
            sda_drive <= 1'b0;
            wr        <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                st        <= LK_RECV;
                bit_cnt   <= '0;
                fidx      <= '0;
                is_read   <= 1'b0;
                sda_drive <= 1'b0;
            end else if (ev.stop) begin
                st        <= LK_IDLE;
                sda_drive <= 1'b0;
            end else begin
                case (st)
                    LK_RECV: begin
                        if (ev.rise) begin
                            shreg   <= {shreg[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev.fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (fidx == 8'd0) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    is_read   <= shreg[0];
                                    sda_drive <= 1'b1;
                                    st        <= LK_ACK_OUT;
                                end else begin
                                    st <= LK_IDLE;
                                end
                            end else begin
                                sda_drive <= 1'b1;
                                st        <= LK_ACK_OUT;
                                if (fidx >= WR_DATA_POS && (fidx - WR_DATA_POS) < NREG_B) begin
                                    wr.en   <= 1'b1;
                                    wr.idx  <= fidx - WR_DATA_POS;
                                    wr.data <= shreg;
                                end
                            end
                        end
                    end
                    LK_ACK_OUT: begin
                        if (ev.fall) begin
                            fidx <= nxt_fidx;
                            if (is_read) begin
                                shreg     <= tx_byte;
                                sda_drive <= ~tx_byte[7];
                                bit_cnt   <= '0;
                                st        <= LK_SEND;
                            end else begin
                                sda_drive <= 1'b0;
                                st        <= LK_RECV;
                            end
                        end
                    end
                    LK_SEND: begin
                        if (ev.fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_drive <= 1'b0;
                                st        <= LK_ACK_IN;
                            end else begin
                                shreg     <= {shreg[6:0], 1'b0};
                                sda_drive <= ~shreg[6];
                                bit_cnt   <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    LK_ACK_IN: begin
                        if (ev.rise) begin
                            ack_seen <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (ack_seen) begin
                                fidx      <= nxt_fidx;
                                shreg     <= tx_byte;
                                sda_drive <= ~tx_byte[7];
                                bit_cnt   <= '0;
                                st        <= LK_SEND;
                            end else begin
                                st <= LK_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_DRIVE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (sda_drive != $past(sda_drive)) |-> $past(ev.fall || ev.start || ev.stop)); // R8

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == LK_IDLE) |-> !sda_drive); // R1

    AST_NO_WRITE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> !is_read); // R5

endmodule

// File: rtl/cfgs_slave.sv
module cfgs_slave
    import cfgs_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         NUM_REGS    = 6,
    parameter logic [6:0] DEV_ADDR    = 7'h69
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_out_en,
    output logic [NUM_REGS*8-1:0] cfg_regs
);

    bus_ev_t ev;
    wr_req_t wr;
    byte_t   rd_idx;
    byte_t   rd_data;

    cfgs_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    cfgs_link #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_link (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr        (wr),
        .sda_drive (sda_out_en)
    );

    cfgs_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs)
    );

endmodule

// File: tb/test_cfgs_slave.sv
module test_cfgs_slave;

    localparam int NREG = 6;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_line;
    logic sda_out_en;
    logic [NREG*8-1:0] cfg_regs;
    logic [7:0] model [NREG];
    int tests_run = 0;
    int tests_failed = 0;

    assign sda_line = m_sda & ~sda_out_en;

    cfgs_slave #(.SYNC_STAGES(2), .NUM_REGS(NREG), .DEV_ADDR(7'h69)) i_cfgs_slave (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (m_scl),
        .sda_in     (sda_line),
        .sda_out_en (sda_out_en),
        .cfg_regs   (cfg_regs)
    );

    always #10 clk = ~clk;

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        if (m_scl == 1'b0) begin
            m_sda = 1'b1; wq();
            m_scl = 1'b1; wq();
        end
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        logic line;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(line);
        ack = ~line;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(~give_ack);
    endtask

    task automatic check_cfg(input string req);
        for (int k = 0; k < NREG; k++)
            check_eq(req, {24'h0, cfg_regs[k*8 +: 8]}, {24'h0, model[k]});
    endtask

    task automatic t_read_all(input string req);
        logic ack;
        logic [7:0] v;
        bus_start();
        wr_byte(8'hD3, ack);
        check_eq("R1 read address ack", {31'h0, ack}, 32'h1);
        rd_byte(1'b1, v);
        check_eq("R5 length byte", {24'h0, v}, 32'h6);
        for (int k = 0; k < NREG; k++) begin
            rd_byte(1'b1, v);
            check_eq(req, {24'h0, v}, {24'h0, model[k] & ((k == 0) ? 8'hFE : 8'hFF)});
        end
        rd_byte(1'b0, v);
        check_eq("R5 read past end", {24'h0, v}, 32'hFF);
        check_eq("R5 released after nack", {31'h0, sda_out_en}, 32'h0);
        bus_stop();
    endtask

    task automatic t_reset();
        model[0] = 8'h07; model[1] = 8'hFF; model[2] = 8'hFF;
        model[3] = 8'h00; model[4] = 8'h00; model[5] = 8'h00;
        check_eq("R7 sda released", {31'h0, sda_out_en}, 32'h0);
        check_cfg("R7 reset value");
        t_read_all("R7 R6 readback of defaults");
    endtask

    task automatic t_full_write();
        logic ack;
        logic [7:0] d [8];
        d = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE, 8'hF0};
        bus_start();
        wr_byte(8'hD2, ack); check_eq("R1 write address ack", {31'h0, ack}, 32'h1);
        wr_byte(8'hA5, ack); check_eq("R2 command ack", {31'h0, ack}, 32'h1);
        wr_byte(8'h3C, ack); check_eq("R2 length ack", {31'h0, ack}, 32'h1);
        for (int k = 0; k < 8; k++) begin
            wr_byte(d[k], ack);
            check_eq((k < NREG) ? "R2 data ack" : "R4 extra byte ack", {31'h0, ack}, 32'h1);
            if (k < NREG) model[k] = d[k];
        end
        bus_stop();
        check_cfg("R2 R4 stored bank");
        t_read_all("R5 readback after write");
    endtask

    task automatic t_partial_write();
        logic ack;
        bus_start();
        wr_byte(8'hD2, ack);
        wr_byte(8'h00, ack);
        wr_byte(8'h00, ack);
        wr_byte(8'hC3, ack); model[0] = 8'hC3;
        wr_byte(8'h5A, ack); model[1] = 8'h5A;
        bus_stop();
        check_cfg("R3 partial write");
    endtask

    task automatic t_bad_addr();
        logic ack;
        bus_start();
        wr_byte(8'hA0, ack);
        check_eq("R1 foreign address no ack", {31'h0, ack}, 32'h0);
        bus_stop();
        bus_start();
        wr_byte(8'hD4, ack);
        check_eq("R1 near address no ack", {31'h0, ack}, 32'h0);
        wr_byte(8'h00, ack);
        check_eq("R1 ignored frame no ack", {31'h0, ack}, 32'h0);
        wr_byte(8'h00, ack);
        wr_byte(8'h11, ack);
        bus_stop();
        check_cfg("R1 bank untouched");
    endtask

    task automatic t_abort();
        logic ack;
        logic [7:0] v;
        bus_start();
        wr_byte(8'hD2, ack);
        wr_byte(8'h00, ack);
        wr_byte(8'h00, ack);
        wr_byte(8'h81, ack); model[0] = 8'h81;
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        check_cfg("R9 stop mid byte");
        bus_start();
        wr_byte(8'hD2, ack);
        wr_byte(8'h00, ack);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_start();
        wr_byte(8'hD3, ack);
        check_eq("R9 repeated start address ack", {31'h0, ack}, 32'h1);
        rd_byte(1'b0, v);
        check_eq("R9 read after repeated start", {24'h0, v}, 32'h6);
        bus_stop();
        check_cfg("R9 bank after abort");
    endtask

    task automatic t_bit0();
        logic ack;
        logic [7:0] v;
        bus_start();
        wr_byte(8'hD2, ack);
        wr_byte(8'h00, ack);
        wr_byte(8'h00, ack);
        wr_byte(8'h01, ack); model[0] = 8'h01;
        bus_stop();
        check_eq("R6 stored bit0 on output", {31'h0, cfg_regs[0]}, 32'h1);
        bus_start();
        wr_byte(8'hD3, ack);
        rd_byte(1'b1, v);
        rd_byte(1'b0, v);
        check_eq("R6 bit0 reads zero", {24'h0, v}, 32'h00);
        bus_stop();
    endtask

    task automatic t_ack_timing();
        logic [7:0] a;
        a = 8'hD2;
        bus_start();
        for (int i = 7; i >= 1; i--) send_bit(a[i]);
        m_sda = a[0]; wq();
        m_scl = 1'b1; wq();
        check_eq("R8 no pull during 8th bit", {31'h0, sda_out_en}, 32'h0);
        wq();
        m_scl = 1'b0; wq();
        check_eq("R8 pull after 8th fall", {31'h0, sda_out_en}, 32'h1);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        check_eq("R8 line low in 9th high", {31'h0, sda_line}, 32'h0);
        wq();
        m_scl = 1'b0; wq();
        check_eq("R8 release after 9th fall", {31'h0, sda_out_en}, 32'h0);
        bus_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_full_write();
        t_partial_write();
        t_bad_addr();
        t_abort();
        t_bit0();
        t_ack_timing();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog R1-frame timeout actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule